// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive FIFOs

This block is a full-duplex SPI master that a processor controls through five word registers on a plain synchronous read/write port. Software puts bytes into a 16-entry transmit queue through a data port. It picks a chip-select line, a clock mode and a divider, and then sets a transfer-active bit. While that bit stays set, the selected chip-select line remains asserted. The engine shifts out every byte it finds in the transmit queue, most significant bit first, and puts each byte it captures into a 16-entry receive queue. Software reads received bytes back through the same data port.

Because the transfer-active bit is separate from the queue contents, a transfer can run longer than one queue load. Software refills the transmit queue when it sees the done flag (transmit queue empty, shifter idle, transfer active). It drains the receive queue when the read-threshold flag rises. The single interrupt output can be enabled for either condition and is forced low whenever no transfer is active.

Registers sit on a word index (byte offset = 4 × index): 0 control/status, 1 data port, 2 clock divider, 3 length store, 4 hold-delay store. A read returns its data one cycle after the read strobe. A read of the data port removes one byte from the receive queue.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word reads 0x00040000 (only the transmit-space bit 18 set), all chip-select outputs are high, sclk is low and irq is low.
- R2: The divider register (index 2, 16 bits), the length register (index 3, 16 bits) and the hold register (index 4, 8 bits) read back what was written, truncated to their width.
- R3: With transfer-active (bit 7) set, the chip-select line numbered by bits [1:0] is driven to its active level, given by bit 21+n (1 = active high, 0 = active low). Every other line sits at the opposite level. Select value 3 activates no line, and clearing bit 7 releases all lines.
- R4: sclk rests at the level of bit 3 (clock polarity). During a byte, its edges are D/2 system clocks apart for divider value D, and D = 0 counts as 65536.
- R5: Bytes leave on mosi MSB first. With bit 2 (phase) clear, data is captured on the first edge of each bit. With bit 2 set, it is captured on the second edge. Each byte removes one transmit entry and adds the captured miso byte to the receive queue.
- R6: The done bit 16 reads 1 exactly when transfer-active is set, the transmit queue is empty and no byte is shifting.
- R7: The transmit queue holds 16 bytes. A data-port write while it is full is dropped. Bit 18 reads 1 while the queue is not full.
- R8: Bit 17 reads 1 while the receive queue holds data, bit 20 while it is full, and bit 19 while it holds 12 or more bytes. A byte captured into a full receive queue is discarded. A data-port read of an empty queue returns 0.
- R9: irq is registered and equals transfer-active AND ((bit 9 AND done) OR (bit 10 AND bit 19)).
- R10: Writing 1 to bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines, per-line polarity |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: 16-entry queues, a read threshold of 12 and a 16-bit divider. With 16-entry queues, the full and overflow cases are reached with a few dozen register writes. With the 16-bit divider, the zero-means-65536 case can be measured within the cycle budget. miso is tied to the inverse of mosi, so every received byte has a known value that differs from the byte sent. A monitor rebuilds each mosi byte at the sampling edge of the programmed mode and compares it against a queue of expected bytes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Register word indices
  localparam int IDX_CTRL = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_DIV  = 2;
  localparam int IDX_LEN  = 3;
  localparam int IDX_HOLD = 4;

  // Control/status bit positions
  localparam int B_CPHA   = 2;
  localparam int B_CPOL   = 3;
  localparam int B_CLRTX  = 4;
  localparam int B_CLRRX  = 5;
  localparam int B_POLALL = 6;
  localparam int B_ACT    = 7;
  localparam int B_IEDONE = 9;
  localparam int B_IERX   = 10;
  localparam int B_DONE   = 16;
  localparam int B_RXANY  = 17;
  localparam int B_TXROOM = 18;
  localparam int B_RXHIGH = 19;
  localparam int B_RXFULL = 20;
  localparam int B_POL0   = 21;

  typedef struct packed {
    logic [2:0] pol;
    logic       ie_rx;
    logic       ie_done;
    logic       act;
    logic       pol_all;
    logic       cpol;
    logic       cpha;
    logic [1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNT_W-1:0] cnt;

  wire do_wr = wr_en && !full;
  wire do_rd = rd_en && !empty;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign count   = cnt;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end

  // R7: a write into a full queue leaves it full and unchanged in size
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !clear) |=> full);
  // R8: occupancy never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int BITS  = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] half,
  input  logic             tx_avail,
  input  logic [BITS-1:0]  tx_byte,
  output logic             tx_pop,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             rx_valid,
  output logic [BITS-1:0]  rx_byte
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [DIV_W-1:0] tick_cnt;
  logic [EW-1:0]    edge_cnt;
  logic [BITS-1:0]  sh_tx, sh_rx;
  logic             busy_q, sclk_q, mosi_q;

  wire tick      = busy_q && (tick_cnt == half - 1'b1);
  wire samp_edge = (edge_cnt[0] == cpha);
  wire last_edge = (edge_cnt == EW'(EDGES-1));

  assign tx_pop = en && !busy_q && tx_avail;
  assign sclk   = sclk_q;
  assign mosi   = mosi_q;
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      tick_cnt <= '0;
      edge_cnt <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else if (!en) begin
      busy_q   <= 1'b0;
      sclk_q   <= cpol;
      tick_cnt <= '0;
      edge_cnt <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_pop) begin
        busy_q   <= 1'b1;
        sclk_q   <= cpol;
        tick_cnt <= '0;
        edge_cnt <= '0;
        sh_tx    <= tx_byte;
        if (!cpha) mosi_q <= tx_byte[BITS-1];
      end else if (busy_q) begin
        if (tick) begin
          tick_cnt <= '0;
          sclk_q   <= ~sclk_q;
          edge_cnt <= edge_cnt + 1'b1;
          if (samp_edge) begin
            sh_rx <= {sh_rx[BITS-2:0], miso};
          end else if (cpha) begin
            mosi_q <= sh_tx[BITS-1];
            sh_tx  <= sh_tx << 1;
          end else begin
            mosi_q <= sh_tx[BITS-2];
            sh_tx  <= sh_tx << 1;
          end
          if (last_edge) begin
            busy_q   <= 1'b0;
            rx_valid <= 1'b1;
            rx_byte  <= cpha ? {sh_rx[BITS-2:0], miso} : sh_rx;
          end
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end else begin
        sclk_q <= cpol;
      end
    end
  end

  // R5: a captured byte is only delivered as a byte finishes
  a_r5_push_after_byte: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!busy_q && $past(busy_q)));
  // R4: sclk rests at the polarity level while idle
  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!busy_q) && $stable(cpol) && !busy_q) |-> (sclk_q == cpol));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RXR_LEVEL  = 12,
  parameter int DIV_W      = 16,
  parameter int NUM_CS     = 3,
  parameter int ADDR_W     = 3,
  parameter int LEN_W      = 16,
  parameter int HOLD_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_o,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  ctrl_t            ctrl;
  logic [DIV_W-1:0] div_q, half;
  logic [LEN_W-1:0] len_q;
  logic [HOLD_W-1:0] hold_q;

  wire sel_ctrl = (bus_addr == ADDR_W'(IDX_CTRL));
  wire sel_data = (bus_addr == ADDR_W'(IDX_DATA));
  wire clr_tx   = bus_wr && sel_ctrl && bus_wdata[B_CLRTX];
  wire clr_rx   = bus_wr && sel_ctrl && bus_wdata[B_CLRRX];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:24], bus_wdata[20:11], bus_wdata[8]};

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      div_q  <= '0;
      len_q  <= '0;
      hold_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        ctrl.sel     <= bus_wdata[1:0];
        ctrl.cpha    <= bus_wdata[B_CPHA];
        ctrl.cpol    <= bus_wdata[B_CPOL];
        ctrl.pol_all <= bus_wdata[B_POLALL];
        ctrl.act     <= bus_wdata[B_ACT];
        ctrl.ie_done <= bus_wdata[B_IEDONE];
        ctrl.ie_rx   <= bus_wdata[B_IERX];
        ctrl.pol     <= bus_wdata[B_POL0+2:B_POL0];
      end
      if (bus_addr == ADDR_W'(IDX_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
      if (bus_addr == ADDR_W'(IDX_LEN))  len_q  <= bus_wdata[LEN_W-1:0];
      if (bus_addr == ADDR_W'(IDX_HOLD)) hold_q <= bus_wdata[HOLD_W-1:0];
    end
  end

  // Half-period of sclk in system clocks; zero selects the largest division
  always_comb begin
    if (div_q == '0)      half = DIV_W'(1) << (DIV_W-1);
    else if (div_q < 2)   half = DIV_W'(1);
    else                  half = div_q >> 1;
  end

  // Queues and shift engine
  logic             tx_empty, tx_full, tx_pop;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic             rx_empty, rx_full, rx_valid, busy;
  logic [CNT_W-1:0] rx_cnt, unused_tx_cnt;

  spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clear(clr_tx),
    .wr_en(bus_wr && sel_data), .wr_data(bus_wdata[7:0]),
    .rd_en(tx_pop), .rd_data(tx_head),
    .empty(tx_empty), .full(tx_full), .count(unused_tx_cnt)
  );

  spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clear(clr_rx),
    .wr_en(rx_valid), .wr_data(rx_byte),
    .rd_en(bus_rd && sel_data), .rd_data(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  spim_shifter #(.BITS(8), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .en(ctrl.act),
    .cpol(ctrl.cpol), .cpha(ctrl.cpha), .half(half),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  wire done  = ctrl.act && tx_empty && !busy;
  wire rx_hi = (rx_cnt >= CNT_W'(RXR_LEVEL));

  // Status word
  logic [31:0] stat;
  always_comb begin
    stat                    = '0;
    stat[1:0]               = ctrl.sel;
    stat[B_CPHA]            = ctrl.cpha;
    stat[B_CPOL]            = ctrl.cpol;
    stat[B_POLALL]          = ctrl.pol_all;
    stat[B_ACT]             = ctrl.act;
    stat[B_IEDONE]          = ctrl.ie_done;
    stat[B_IERX]            = ctrl.ie_rx;
    stat[B_DONE]            = done;
    stat[B_RXANY]           = !rx_empty;
    stat[B_TXROOM]          = !tx_full;
    stat[B_RXHIGH]          = rx_hi;
    stat[B_RXFULL]          = rx_full;
    stat[B_POL0+2:B_POL0]   = ctrl.pol;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_ctrl)                           bus_rdata <= stat;
      else if (sel_data)                      bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_head};
      else if (bus_addr == ADDR_W'(IDX_DIV))  bus_rdata <= 32'(div_q);
      else if (bus_addr == ADDR_W'(IDX_LEN))  bus_rdata <= 32'(len_q);
      else if (bus_addr == ADDR_W'(IDX_HOLD)) bus_rdata <= 32'(hold_q);
      else                                    bus_rdata <= '0;
    end
  end

  // Chip-select lines
  logic [NUM_CS-1:0] cs_hit, cs_lvl, cs_act;
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_hit[i] = ctrl.act && (ctrl.sel == 2'(i));
    assign cs_lvl[i] = cs_hit[i] ~^ ctrl.pol[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o   <= '1;
      cs_act <= '0;
      irq    <= 1'b0;
    end else begin
      cs_o   <= cs_lvl;
      cs_act <= cs_hit;
      irq    <= ctrl.act && ((ctrl.ie_done && done) || (ctrl.ie_rx && rx_hi));
    end
  end

  // R9: no interrupt follows a cycle without an active transfer
  a_r9_irq_needs_act: assert property (@(posedge clk) disable iff (rst)
    !ctrl.act |=> !irq);
  // R3: at most one chip-select line is active
  a_r3_one_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_act));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [2:0]  cs_o;
  logic        irq;

  assign miso = ~mosi;

  spi_fifo_master u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard of bytes expected on mosi
  logic [7:0] exp_q[$];
  bit         mon_on = 0;
  bit         mon_cpol = 0, mon_cpha = 0;
  logic       mon_prev = 0;
  logic [7:0] mon_byte = '0;
  int         mon_bits = 0;

  always @(negedge clk) begin
    if (!mon_on) begin
      mon_bits = 0;
    end else if (sclk !== mon_prev) begin
      if ((sclk != mon_cpol) == !mon_cpha) begin
        mon_byte = {mon_byte[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 unexpected mosi byte actual=%h expected=none", mon_byte);
          end else begin
            check("R5 mosi byte", {24'd0, mon_byte}, {24'd0, exp_q.pop_front()});
          end
        end
      end
    end
    mon_prev = sclk;
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(idx); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(idx);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    exp_q.push_back(b);
    wr(1, {24'd0, b});
  endtask

  task automatic read_rx(input string req, input logic [7:0] sent);
    logic [31:0] d;
    rd(1, d);
    check(req, d, {24'd0, ~sent});
  endtask

  task automatic wait_done();
    logic [31:0] d;
    int tries = 0;
    d = '0;
    while (!d[16] && tries < 4000) begin
      rd(0, d);
      tries++;
    end
    if (!d[16]) begin
      checks++; errors++;
      $display("FAIL R6 done never set actual=%h expected=bit16", d);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles between the first and second sclk edges after the call
  task automatic edge_gap(output int gap);
    logic start;
    int   n = 0;
    start = sclk;
    while (sclk === start && n < 70000) begin @(negedge clk); n++; end
    start = sclk;
    gap = 0;
    while (sclk === start && gap < 70000) begin @(negedge clk); gap++; end
  endtask

  logic [7:0] arr [16];

  initial begin
    logic [31:0] d;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(0, d);
    check("R1 ctrl reset", d, 32'h0004_0000);
    check("R1 cs reset", {29'd0, cs_o}, 32'd7);
    check("R1 sclk/irq reset", {30'd0, sclk, irq}, 32'd0);

    // R2: storage registers
    wr(2, 32'h0000_0004);
    rd(2, d); check("R2 divider readback", d, 32'h4);
    wr(3, 32'h0001_0034);
    rd(3, d); check("R2 length truncated", d, 32'h34);
    wr(4, 32'h0000_015A);
    rd(4, d); check("R2 hold truncated", d, 32'h5A);

    // R5/R3: mode 0 on line 1
    mon_cpol = 0; mon_cpha = 0; mon_on = 1;
    push(8'hA5); push(8'h3C); push(8'hF0);
    wr(0, 32'h0000_0081);
    idle(2);
    check("R3 line1 active low", {29'd0, cs_o}, 32'd5);
    wait_done();
    read_rx("R5 mode0 rx0", 8'hA5);
    read_rx("R5 mode0 rx1", 8'h3C);
    read_rx("R5 mode0 rx2", 8'hF0);
    rd(0, d); check("R6 done status", d, 32'h0005_0081);
    wr(0, 32'h0);
    idle(2);
    check("R3 release", {29'd0, cs_o}, 32'd7);

    // R4/R3: mode 3 on line 2, active high
    mon_on = 0;
    wr(0, 32'h0080_000E);
    idle(3);
    check("R4 idle high", {31'd0, sclk}, 32'd1);
    check("R3 line2 inactive low", {29'd0, cs_o}, 32'd3);
    mon_cpol = 1; mon_cpha = 1; mon_on = 1;
    push(8'h81); push(8'h7E);
    wr(0, 32'h0080_008E);
    idle(2);
    check("R3 line2 active high", {29'd0, cs_o}, 32'd7);
    wait_done();
    read_rx("R5 mode3 rx0", 8'h81);
    read_rx("R5 mode3 rx1", 8'h7E);
    mon_on = 0;
    wr(0, 32'h0);
    idle(3);

    // R4: edge spacing for divider 8
    mon_cpol = 0; mon_cpha = 0; mon_on = 1;
    wr(2, 32'd8);
    push(8'h5B);
    wr(0, 32'h0000_0080);
    edge_gap(gap);
    check("R4 divider 8 gap", gap, 32'd4);
    wait_done();
    read_rx("R5 div8 rx", 8'h5B);
    wr(0, 32'h0);
    wr(2, 32'd4);

    // R7/R8: full queues
    for (int i = 0; i < 16; i++) begin
      arr[i] = 8'(i * 29 + 3);
      push(arr[i]);
    end
    rd(0, d); check("R7 tx full no room", d, 32'h0);
    wr(1, 32'h99);
    wr(0, 32'h0000_0080);
    wait_done();
    rd(0, d); check("R8 rx full flags", d, 32'h001F_0080);
    push(8'h55);
    wait_done();
    for (int i = 0; i < 16; i++) read_rx("R8 rx kept", arr[i]);
    rd(1, d); check("R8 empty read zero", d, 32'h0);
    wr(0, 32'h0);

    // R9: interrupt sources
    wr(0, 32'h0000_0280);
    idle(3);
    check("R9 done irq", {31'd0, irq}, 32'd1);
    wr(0, 32'h0000_0200);
    idle(2);
    check("R9 irq off without act", {31'd0, irq}, 32'd0);
    wr(0, 32'h0);
    for (int i = 0; i < 12; i++) begin
      arr[i] = 8'(i * 13 + 100);
      push(arr[i]);
    end
    wr(0, 32'h0000_0480);
    idle(2);
    check("R9 rx irq low early", {31'd0, irq}, 32'd0);
    wait_done();
    idle(2);
    check("R9 rx threshold irq", {31'd0, irq}, 32'd1);
    read_rx("R9 rx first", arr[0]);
    idle(2);
    check("R9 irq below threshold", {31'd0, irq}, 32'd0);
    for (int i = 1; i < 12; i++) read_rx("R9 drain", arr[i]);
    wr(0, 32'h0);

    // R10: queue clears
    wr(1, 32'h11); wr(1, 32'h22); wr(1, 32'h33);
    wr(0, 32'h0000_0010);
    rd(0, d); check("R10 clear bits read 0", d, 32'h0004_0000);
    wr(0, 32'h0000_0080);
    idle(3);
    rd(0, d); check("R10 tx cleared, done", d, 32'h0005_0080);
    push(8'hC3); push(8'h3C);
    wait_done();
    wr(0, 32'h0000_0020);
    rd(0, d); check("R10 rx cleared", d, 32'h0004_0000);

    // R3: select value 3
    wr(0, 32'h0000_0083);
    idle(2);
    check("R3 sel3 none (low pol)", {29'd0, cs_o}, 32'd7);
    wr(0, 32'h00E0_0083);
    idle(2);
    check("R3 sel3 none (high pol)", {29'd0, cs_o}, 32'd0);
    wr(0, 32'h0);

    // R4: divider zero means 65536
    mon_on = 0;
    wr(2, 32'd0);
    wr(1, 32'hA0);
    wr(0, 32'h0000_0080);
    edge_gap(gap);
    check("R4 divider zero gap", gap, 32'd32768);
    wr(0, 32'h0000_0030);
    rd(0, d); check("R10 abort and clear", d, 32'h0004_0000);

    check("R5 scoreboard drained", exp_q.size(), 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule